// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block sits on the read path of a flash array. While an embedded program or erase runs, or while an erase is suspended, it replaces selected bits of the read data with status information. Host software polls these bits to learn whether the operation has finished. Bit 7 is a data-polling bit, bit 6 is the main toggle bit, and bit 2 is a toggle bit that marks the sector holding the suspended erase. All other bits always carry array data.

The block takes the following inputs:
- The operation kind.
- A flag showing that a program is running in another sector during an erase-suspend.
- The busy flag.
- The sector being read and the sector that is busy or suspended.
- A read strobe.
- The latched program data.
- Command sequence markers: one marks the start of a command, and one marks each write-enable pulse.

Status is shown only after the last write-enable pulse of the command has been seen. Before that, reads return array data.

Top module: `fsb_status_gen`

## Requirements
- R1: Program (op_kind 1) with busy high and status valid: bit 7 reads the inverse of prog_data bit 7, bit 6 alternates on each read strobe, and bit 2 reads 0.
- R2: Erase (op_kind 2) with busy high and status valid: bit 7 reads 0, and bits 6 and 2 both alternate on each read strobe.
- R3: Erase-suspend (op_kind 3) with rd_sect equal to tgt_sect: bit 6 reads 1, bit 2 alternates on each read strobe, and bit 7 passes array data.
- R4: Erase-suspend with rd_sect different from tgt_sect and no program running: the whole read returns arr_data.
- R5: Erase-suspend with susp_prog high, busy high, status valid and a read from another sector: bits 7 and 6 behave as in R1, and bit 2 reads 0.
- R6: Status counts as valid only once at least 4 we_pulse strobes (program, or a program during suspend) or 6 strobes (erase) have arrived since the last op_start. Until then the read returns arr_data.
- R7: With op_kind 0, or with busy low outside erase-suspend, the read returns arr_data and the toggle bits do not advance.
- R8: The toggle bits change only on a read strobe that is returning a toggling status. op_start clears them, so the first status read after a start shows 0 on each toggle bit.
- R9: Bits 5, 4, 3, 1 and 0 always equal arr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_kind | input | 2 | 0 idle, 1 program, 2 erase, 3 erase-suspend |
| susp_prog | input | 1 | A program is running in another sector during erase-suspend |
| busy | input | 1 | The embedded operation is in progress |
| op_start | input | 1 | One-cycle marker for the start of a command sequence |
| we_pulse | input | 1 | One-cycle marker for each completed write-enable pulse |
| rd_sect | input | SECT_W | Sector addressed by the current read |
| tgt_sect | input | SECT_W | Sector that is busy or erase-suspended |
| rd_stb | input | 1 | One-cycle read strobe |
| prog_data | input | DATA_W | Latched program data |
| arr_data | input | DATA_W | Data read from the array |
| dout | output | DATA_W | Read data returned to the host |

## Verification
The assertions assume three things about the inputs:
- op_start and we_pulse are single-cycle markers that never occur in the same cycle.
- op_kind and susp_prog stay steady from op_start until the reads of that command are finished.
- rd_stb is high for exactly one cycle per read.

The stimulus meets these assumptions:
- It changes the mode only together with op_start.
- It places every strobe between falling clock edges.
- It separates consecutive reads with an idle cycle.

Because of this, each toggle bit's sequence is known exactly from the number of strobes since the last start.

// File: rtl/fsb_pkg.sv
// Package: shared types for the flash write status bit generator.
// Assumes op_kind encodings 0..3 as listed in the brief.
package fsb_pkg;

    // Operation kind reported by the command logic.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_SUSP  = 2'd3
    } op_kind_e;

    // Source selected for one status bit position.
    typedef enum logic [2:0] {
        SRC_PASS = 3'd0,
        SRC_TGL  = 3'd1,
        SRC_CPL  = 3'd2,
        SRC_ZERO = 3'd3,
        SRC_ONE  = 3'd4
    } bit_src_e;

    // Per-bit selection produced by the mode decoder.
    typedef struct packed {
        bit_src_e src_poll;
        bit_src_e src_tgl;
        bit_src_e src_sect;
    } stat_sel_t;

    // Resolve one output bit from its selected source.
    function automatic logic pick_bit(bit_src_e s, logic arr, logic tg, logic pd);
        logic r;
        unique case (s)
            SRC_TGL:  r = tg;
            SRC_CPL:  r = ~pd;
            SRC_ZERO: r = 1'b0;
            SRC_ONE:  r = 1'b1;
            default:  r = arr;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsb_we_cnt.sv
// Module: counts write-enable pulses since the last command start and
// reports whether the program or erase sequence length has been reached.
// Assumes op_start and we_pulse are single-cycle and op_start has priority.
module fsb_we_cnt #(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic we_pulse,
    output logic prog_ok,
    output logic erase_ok
);
    localparam int CNT_W = $clog2(ERASE_PULSES + 1);
    localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(PROG_PULSES);
    localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(ERASE_PULSES);

    logic [CNT_W-1:0] cnt_q;

    // Count pulses, cleared at command start, saturating at the erase length.
    always_ff @(posedge clk) begin
        if (!rst_n || op_start) begin
            cnt_q <= '0;
        end else if (we_pulse && cnt_q != ERASE_LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the count with the sequence lengths.
    always_comb begin
        prog_ok  = (cnt_q >= PROG_LIM);
        erase_ok = (cnt_q >= ERASE_LIM);
    end

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (!prog_ok && !erase_ok));                     // R6
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ERASE_LIM);                                       // R6
    AST_CNT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        erase_ok |-> prog_ok);                                     // R6

endmodule

// File: rtl/fsb_tgl_ff.sv
// Module: a single toggle bit. It flips when advanced and clears on command
// start. Assumes clr has priority over adv.
module fsb_tgl_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    // Hold, flip on advance, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= ~q;
        end
    end

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (q != $past(q)));                        // R8
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(q));                            // R8
    AST_TGL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);                                               // R8

endmodule

// File: rtl/fsb_mode_dec.sv
// Module: decodes the operation state into a source for each status bit.
// Assumes susp_prog is meaningful only in erase-suspend.
module fsb_mode_dec
    import fsb_pkg::*;
(
    input  logic      [1:0] op_kind,
    input  logic            susp_prog,
    input  logic            busy,
    input  logic            same_sect,
    input  logic            prog_ok,
    input  logic            erase_ok,
    output stat_sel_t       sel
);
    op_kind_e op;

    // Select the source for the polling bit and the two toggle bits.
    always_comb begin
        op  = op_kind_e'(op_kind);
        sel = '{src_poll: SRC_PASS, src_tgl: SRC_PASS, src_sect: SRC_PASS};
        unique case (op)
            OP_PROG: begin
                if (busy && prog_ok) begin
                    sel = '{src_poll: SRC_CPL, src_tgl: SRC_TGL, src_sect: SRC_ZERO};
                end
            end
            OP_ERASE: begin
                if (busy && erase_ok) begin
                    sel = '{src_poll: SRC_ZERO, src_tgl: SRC_TGL, src_sect: SRC_TGL};
                end
            end
            OP_SUSP: begin
                if (same_sect) begin
                    sel = '{src_poll: SRC_PASS, src_tgl: SRC_ONE, src_sect: SRC_TGL};
                end else if (susp_prog && busy && prog_ok) begin
                    sel = '{src_poll: SRC_CPL, src_tgl: SRC_TGL, src_sect: SRC_ZERO};
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fsb_status_gen.sv
// Module: top of the status bit generator. It replaces the polling bit and
// the toggle bits of the read data with status while an operation is active.
// Assumes rd_stb is high for one cycle per read and that the mode is steady
// for the duration of a command.
module fsb_status_gen
    import fsb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SECT_W       = 4,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6,
    parameter int POLL_BIT     = 7,
    parameter int TGL_BIT      = 6,
    parameter int SECT_BIT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_kind,
    input  logic              susp_prog,
    input  logic              busy,
    input  logic              op_start,
    input  logic              we_pulse,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [SECT_W-1:0] tgt_sect,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout
);
    localparam int NUM_TGL = 2;

    logic               prog_ok;
    logic               erase_ok;
    logic               same_sect;
    stat_sel_t          sel;
    logic [NUM_TGL-1:0] tgl_q;
    logic [NUM_TGL-1:0] tgl_adv;

    // Compare the read sector with the busy or suspended sector.
    always_comb same_sect = (rd_sect == tgt_sect);

    fsb_we_cnt #(
        .PROG_PULSES  (PROG_PULSES),
        .ERASE_PULSES (ERASE_PULSES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .we_pulse (we_pulse),
        .prog_ok  (prog_ok),
        .erase_ok (erase_ok)
    );

    fsb_mode_dec u_dec (
        .op_kind   (op_kind),
        .susp_prog (susp_prog),
        .busy      (busy),
        .same_sect (same_sect),
        .prog_ok   (prog_ok),
        .erase_ok  (erase_ok),
        .sel       (sel)
    );

    // Advance each toggle bit only on a strobe that returns toggling status.
    always_comb begin
        tgl_adv[0] = rd_stb && (sel.src_tgl  == SRC_TGL);
        tgl_adv[1] = rd_stb && (sel.src_sect == SRC_TGL);
    end

    for (genvar t = 0; t < NUM_TGL; t++) begin : g_tgl
        fsb_tgl_ff u_tgl (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (op_start),
            .adv   (tgl_adv[t]),
            .q     (tgl_q[t])
        );
    end

    // Output mux per bit position: status bits get a source, the rest pass through.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        if (g == POLL_BIT) begin : g_poll
            always_comb dout[g] = pick_bit(sel.src_poll, arr_data[g], 1'b0, prog_data[g]);
        end else if (g == TGL_BIT) begin : g_t6
            always_comb dout[g] = pick_bit(sel.src_tgl, arr_data[g], tgl_q[0], prog_data[g]);
        end else if (g == SECT_BIT) begin : g_t2
            always_comb dout[g] = pick_bit(sel.src_sect, arr_data[g], tgl_q[1], prog_data[g]);
        end else begin : g_pass
            always_comb dout[g] = arr_data[g];
        end
    end

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_IDLE) |-> (dout == arr_data));              // R7
    AST_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_kind != OP_SUSP) |-> (dout == arr_data));     // R7
    AST_SUSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_SUSP && same_sect) |-> dout[TGL_BIT]);      // R3
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_ERASE && busy && erase_ok) |-> !dout[POLL_BIT]); // R2
    AST_PROG_SECT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_PROG && busy && prog_ok) |-> !dout[SECT_BIT]);   // R1
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_PROG && busy && prog_ok)
            |-> (dout[POLL_BIT] != prog_data[POLL_BIT]));          // R1

endmodule

// File: tb/fsb_status_gen_bench.sv
module fsb_status_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       susp_prog = 1'b0;
    logic       busy = 1'b0;
    logic       op_start = 1'b0;
    logic       we_pulse = 1'b0;
    logic [3:0] rd_sect = 4'd0;
    logic [3:0] tgt_sect = 4'd3;
    logic       rd_stb = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    fsb_status_gen u_fsb_status_gen (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .susp_prog(susp_prog),
        .busy(busy), .op_start(op_start), .we_pulse(we_pulse),
        .rd_sect(rd_sect), .tgt_sect(tgt_sect), .rd_stb(rd_stb),
        .prog_data(prog_data), .arr_data(arr_data), .dout(dout)
    );

    // op, susp_prog, busy, same sector, pulses, arr, prog data, read 1, read 2
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b1, 1'b1, 3'd4, 8'hA5, 8'h3C, 8'hA1, 8'hE1}, // R1
        {2'd1, 1'b0, 1'b1, 1'b1, 3'd3, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R6
        {2'd2, 1'b0, 1'b1, 1'b1, 3'd6, 8'hA5, 8'h3C, 8'h21, 8'h65}, // R2
        {2'd2, 1'b0, 1'b1, 1'b1, 3'd5, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R6
        {2'd3, 1'b0, 1'b0, 1'b1, 3'd0, 8'hA5, 8'h3C, 8'hE1, 8'hE5}, // R3
        {2'd3, 1'b0, 1'b1, 1'b0, 3'd4, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R4
        {2'd3, 1'b1, 1'b1, 1'b0, 3'd4, 8'hA5, 8'h3C, 8'hA1, 8'hE1}, // R5
        {2'd3, 1'b1, 1'b1, 1'b0, 3'd3, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R6
        {2'd1, 1'b0, 1'b0, 1'b1, 3'd4, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R7
        {2'd0, 1'b0, 1'b1, 1'b1, 3'd6, 8'hA5, 8'h3C, 8'hA5, 8'hA5}, // R7
        {2'd1, 1'b0, 1'b1, 1'b1, 3'd4, 8'h5A, 8'hFF, 8'h1A, 8'h5A}, // R1 R9
        {2'd2, 1'b0, 1'b1, 1'b1, 3'd6, 8'h5A, 8'hFF, 8'h1A, 8'h5E}, // R2 R9
        {2'd3, 1'b0, 1'b0, 1'b1, 3'd0, 8'h5A, 8'hFF, 8'h5A, 8'h5E}, // R3
        {2'd3, 1'b1, 1'b1, 1'b1, 3'd4, 8'hA5, 8'h3C, 8'hE1, 8'hE5}  // R3
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected %h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [1:0] op, input logic sp, input logic bz,
                             input logic same, input int np);
        @(negedge clk);
        op_kind = op; susp_prog = sp; busy = bz;
        rd_sect = same ? 4'd3 : 4'd5;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        for (int i = 0; i < np; i++) begin
            we_pulse = 1'b1;
            @(negedge clk);
            we_pulse = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 check(req, dout, exp);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        arr_data = 8'hC3;
        #1 check("R7 reset", dout, 8'hC3);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            arr_data  = VEC[v][31:24];
            prog_data = VEC[v][23:16];
            start_cmd(VEC[v][39:38], VEC[v][37], VEC[v][36], VEC[v][35], int'(VEC[v][34:32]));
            do_read($sformatf("vec%0d read1", v), VEC[v][15:8]);
            do_read($sformatf("vec%0d read2", v), VEC[v][7:0]);
        end
        // R8: no strobe, no advance
        arr_data = 8'hA5; prog_data = 8'h3C;
        start_cmd(2'd1, 1'b0, 1'b1, 1'b1, 4);
        repeat (5) @(negedge clk);
        do_read("R8 idle cycles", 8'hA1);
        // R8: restart clears toggles after an odd number of reads
        start_cmd(2'd2, 1'b0, 1'b1, 1'b1, 6);
        do_read("R8 pre a", 8'h21);
        do_read("R8 pre b", 8'h65);
        do_read("R8 pre c", 8'h21);
        start_cmd(2'd2, 1'b0, 1'b1, 1'b1, 6);
        do_read("R8 after restart", 8'h21);
        // R7: strobes while not busy leave toggles untouched
        start_cmd(2'd1, 1'b0, 1'b0, 1'b1, 4);
        do_read("R7 not busy a", 8'hA5);
        do_read("R7 not busy b", 8'hA5);
        @(negedge clk); busy = 1'b1;
        do_read("R7 then busy", 8'hA1);
        // R6: extra pulses beyond the erase length keep status valid
        start_cmd(2'd2, 1'b0, 1'b1, 1'b1, 7);
        do_read("R6 saturate", 8'h21);
        // R7: operation ends, true data returns
        @(negedge clk); busy = 1'b0;
        do_read("R7 op ended", 8'hA5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule